// File: doc/BRIEF.md
# Cycle-Prescaled Overflow Interrupt Timer

This block raises a cartridge-side interrupt request after a programmable number of CPU cycles. A prescaler counts enabled CPU cycle ticks. Every 114 ticks it steps an 8-bit up-counter once. When a step finds the counter at 0xFF, the counter reloads from an 8-bit latch and the interrupt request goes high. The delay from arming to the first interrupt is therefore (256 − latch) × 114 ticks.

Software loads the latch one nibble at a time through two register addresses. A third address holds a 2-bit control field. Control bit 1 arms counting. Control bit 0 chooses whether the timer keeps running after an overflow or stops. Every write to the control address acknowledges a pending interrupt.

Top module: `cyc_irq_timer`

## Requirements
- R1: The prescaler counts ticks from 0 to 113 and never reaches 114. On the tick where it holds 113 it returns to 0 and steps the counter once.
- R2: A write whose address ANDed with 0xF00C equals 0xF008 sets the control field from data bits 1:0. The same write clears `irq` on the next cycle.
- R3: A control write with data bit 1 set loads the counter from the latch and zeroes the prescaler. Re-arming part-way through a count therefore restarts the full delay.
- R4: Counter and prescaler change only on cycles where `cyc_tick` is high and control bit 1 is set, or on a control write. Idle cycles and a disarmed timer add no delay progress.
- R5: A step that finds the counter at 0xFF reloads the counter from the latch and sets `irq`. Any other step increments the counter. The first `irq` therefore rises exactly (256 − latch) × 114 ticks after arming, and not one tick earlier.
- R6: When `irq` fires, the control field becomes 3 if control bit 0 was set (repeating) and 0 if it was clear (one-shot).
- R7: After reset, `irq` is low and the latch, counter, prescaler and control field are all zero. Arming straight after reset gives a 29184-tick delay.
- R8: `irq` is a level. It stays high until the next control write. A further overflow while it is pending leaves it high.
- R9: The masked address 0xF000 loads latch bits 3:0 from data bits 3:0. The masked address 0xF004 loads latch bits 7:4 from data bits 3:0. Writes to other masked addresses, such as 0xF00C or 0xE000, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| cyc_tick | input | 1 | High for each CPU cycle to be counted |
| irq | output | 1 | Interrupt request level |

## Verification
Each latch value from 0xF0 to 0xFF is armed in turn, along with 0x00, 0x80 and the value left by reset. For each, the bench checks that `irq` is still low one tick before (256 − latch) × 114 ticks and high exactly on that tick. This separates an off-by-one in the prescaler from one in the counter wrap. Further patterns check that gated and idle cycles add no progress, and that re-arming or disarming part-way through a count behaves as required. Latch writes are also issued through aliased addresses and non-decoded addresses, and the delay that follows shows whether each write landed or was ignored. Repeating and one-shot runs check that `irq` holds until acknowledged.

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer #(
  parameter int          PRESCALE = 114,
  parameter int          CNT_W    = 8,
  parameter logic [15:0] DEC_MASK = 16'hF00C,
  parameter logic [15:0] A_LO     = 16'hF000,
  parameter logic [15:0] A_HI     = 16'hF004,
  parameter logic [15:0] A_CTL    = 16'hF008
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_we,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        cyc_tick,
  output logic        irq
);
  localparam int PRE_W = $clog2(PRESCALE);
  localparam int NIB   = CNT_W / 2;

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt, latch;
  logic [1:0]       mode;

  wire [15:0] dec    = cpu_addr & DEC_MASK;
  wire        wr_lo  = cpu_we && dec == A_LO;
  wire        wr_hi  = cpu_we && dec == A_HI;
  wire        wr_ctl = cpu_we && dec == A_CTL;
  wire        run    = mode[1] && cyc_tick;
  wire        step   = run && pre == PRE_W'(PRESCALE - 1);
  wire        wrap   = step && cnt == {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre   <= '0;
      cnt   <= '0;
      latch <= '0;
      mode  <= '0;
      irq   <= 1'b0;
    end else begin
      if (wr_lo) latch[NIB-1:0]     <= cpu_data[NIB-1:0];
      if (wr_hi) latch[CNT_W-1:NIB] <= cpu_data[NIB-1:0];
      if (wr_ctl) begin
        mode <= cpu_data[1:0];
        irq  <= 1'b0;
        if (cpu_data[1]) begin
          cnt <= latch;
          pre <= '0;
        end
      end else if (run) begin
        pre <= step ? '0 : pre + 1'b1;
        if (wrap) begin
          cnt  <= latch;
          irq  <= 1'b1;
          mode <= {2{mode[0]}};
        end else if (step) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r1_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
    pre < PRE_W'(PRESCALE));
  a_r2_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> !irq);
  a_r3_arm: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && cpu_data[1] |=> pre == '0 && cnt == $past(latch));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !wr_ctl |=> $stable(cnt) && $stable(pre));
  a_r5_fire_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cnt) == {CNT_W{1'b1}} && cnt == $past(latch));
  a_r6_mode_after: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> mode == {2{$past(mode[0])}});
  a_r8_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !wr_ctl |=> irq);
endmodule

// File: tb/cyc_irq_timer_tb_top.sv
module cyc_irq_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, cpu_we = 1'b0, cyc_tick = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        irq;
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  cyc_irq_timer dut_i (.clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .cyc_tick(cyc_tick), .irq(irq));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s irq=%b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_data = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    cyc_tick = 1'b1;
    repeat (n) @(negedge clk);
    cyc_tick = 1'b0;
  endtask

  task automatic set_latch(input logic [7:0] v);
    wr(16'hF000, {4'h0, v[3:0]});
    wr(16'hF004, {4'h0, v[7:4]});
  endtask

  // expects irq low at N-1 ticks after arming and high at N
  task automatic measure(input string req, input int n);
    ticks(n - 1);
    chk(req, irq, 1'b0);
    ticks(1);
    chk(req, irq, 1'b1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R7 reset irq", irq, 1'b0);
    // R7: latch zero after reset
    wr(16'hF008, 8'h02);
    measure("R7 reset latch delay", 256 * 114);
    wr(16'hF008, 8'h00);
    chk("R2 ack clears", irq, 1'b0);

    // R5/R1 sweep of latch values
    for (int v = 8'hF0; v <= 8'hFF; v++) begin
      set_latch(v[7:0]);
      wr(16'hF008, 8'h02);
      measure("R5 sweep", (256 - v) * 114);
      wr(16'hF008, 8'h00);
    end
    set_latch(8'h80);
    wr(16'hF008, 8'h03);
    measure("R5 latch 0x80", 128 * 114);
    wr(16'hF008, 8'h00);

    // R9: aliased addresses load nibbles; undecoded writes ignored
    wr(16'hF3F0, 8'hFD);
    wr(16'hF7F4, 8'hAF);
    wr(16'hF00C, 8'h00);
    wr(16'hE000, 8'h00);
    wr(16'hF008, 8'h02);
    ticks(50);
    wr(16'hF00C, 8'h03);
    wr(16'hF000, 8'h00);
    chk("R9 undecoded no irq", irq, 1'b0);
    // latch now F0 in effect only after re-arm; current run uses FD
    measure("R9 nibble latch", 3 * 114 - 50);
    wr(16'hF008, 8'h00);

    // R4: idle cycles interleaved with ticks count only ticks
    set_latch(8'hFE);
    wr(16'hF008, 8'h02);
    for (int i = 0; i < 227; i++) begin
      ticks(1);
      repeat (2) @(negedge clk);
    end
    chk("R4 gaps not counted", irq, 1'b0);
    ticks(1);
    chk("R4 gaps exact", irq, 1'b1);
    // R4: disarmed timer does not count
    wr(16'hF008, 8'h02);
    ticks(100);
    wr(16'hF008, 8'h01);
    ticks(1000);
    chk("R4 disarmed", irq, 1'b0);

    // R3: re-arm mid count restarts full delay
    wr(16'hF008, 8'h02);
    ticks(150);
    wr(16'hF008, 8'h02);
    measure("R3 rearm restart", 228);

    // R8: pending irq held, and further overflows keep it high
    wr(16'hF008, 8'h03);
    ticks(228);
    chk("R8 fire repeat", irq, 1'b1);
    ticks(700);
    chk("R6 R8 repeat held", irq, 1'b1);
    wr(16'hF008, 8'h00);
    chk("R2 ack repeat", irq, 1'b0);
    ticks(500);
    chk("R2 stopped", irq, 1'b0);

    // R6: one-shot holds irq after firing
    wr(16'hF008, 8'h02);
    ticks(228);
    chk("R6 oneshot fire", irq, 1'b1);
    ticks(500);
    chk("R6 oneshot held", irq, 1'b1);
    wr(16'hF008, 8'h00);
    chk("R6 oneshot ack", irq, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule